// File: doc/BRIEF.md
# Multi-Channel PWM with Staged Configuration Commit

This block generates one pulse-width modulated output per channel. Each channel owns a single 32-bit control word that software writes through a simple word-wide register port, with the channel index as the address. The waveform comes from a phase accumulator. Every clock it adds a programmed frequency step, modulo 2^N − 1, where N is the step width. The output is high while the top byte of the accumulator is at or above a programmed threshold, so a larger threshold gives a shorter high time.

Software writes a new step and threshold together with a commit-request flag. The new values sit in the control word only. They move into the active copy that drives the waveform at the start of the next output period, and the hardware then clears the request flag. The enable flag acts only after at least one commit. A write that lands while a commit request is still pending locks the channel. From then on the channel's waveform ignores every write, and only reset releases it.

Typical use: software writes the word with the request flag set, polls until the flag reads back as zero, and only then writes again.

Top module: `pwm_stage`

## Requirements
- R1: After reset every control word reads 0 and every output is low.
- R2: While running, a channel's accumulator adds the active step (bits [8 +: N]) each clock modulo 2^N − 1. With a step of (2^N − 1)/P the output repeats every P clocks. With N=16, a step of 13107 and a threshold of 128, 15 consecutive clocks hold exactly 6 high cycles.
- R3: The output is high exactly when the accumulator's top 8 bits are greater than or equal to the active threshold (bits [7:0]). With N=16 and a step of 4369, 15 consecutive clocks hold 15, 7, 3 and 0 high cycles for thresholds 0, 128, 200 and 255.
- R4: A write stores the word only. Step and threshold become active when a pending request (bit 30) is committed. A commit happens on the next wrap of a running channel, or on the next clock of an idle one. The commit clears bit 30 in the word.
- R5: The enable flag (bit 31) has no effect until at least one commit has happened. Before that the output stays low.
- R6: Clearing the enable flag drives the output low from the second clock edge after the write and resets the accumulator. The active values are kept, so setting the flag again resumes the same waveform without a new request.
- R7: A write to a channel whose bit 30 is still set locks that channel until reset. Later writes are stored and read back verbatim, but the waveform keeps its active values and run state.
- R8: Channels are independent: the address selects the channel, a read returns that channel's word, and locking or reconfiguring one channel does not disturb another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the addressed control word |
| addr | input | AW | Channel index for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Control word of the addressed channel (combinational) |
| pwm_out | output | NUM_CH | One waveform output per channel |

## Verification
The assertions assume that no write reaches a channel whose request is pending unless a lock is the intended outcome. They also assume that the address is always below the channel count and that a running channel has a nonzero step. The stimulus keeps to these rules: after each request it waits longer than one full output period before the next write to that channel. It breaks the pending-write rule on purpose only once, in the lock scenario. Every measurement window starts after the accumulator has returned to a multiple of the step, so the high count per window is exact.

// File: rtl/pwm_stage_pkg.sv
package pwm_stage_pkg;
    localparam int WORD_W  = 32;
    localparam int DIV_W   = 8;
    localparam int BU_LSB  = 8;
    localparam int UPD_BIT = 30;
    localparam int EN_BIT  = 31;

    typedef enum logic [1:0] {
        CH_IDLE    = 2'd0,
        CH_RUN     = 2'd1,
        CH_LOCKED  = 2'd2
    } ch_mode_e;

    function automatic logic req_pending(input logic [WORD_W-1:0] w);
        return w[UPD_BIT];
    endfunction

    function automatic logic [DIV_W-1:0] thr_of(input logic [WORD_W-1:0] w);
        return w[DIV_W-1:0];
    endfunction
endpackage

// File: rtl/pwm_stage_ctl.sv
module pwm_stage_ctl
    import pwm_stage_pkg::*;
#(
    parameter int BU_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              wrap,
    output logic [WORD_W-1:0] word_o,
    output logic [BU_W-1:0]   step_o,
    output logic [DIV_W-1:0]  thr_o,
    output logic              run_o
);
    logic [WORD_W-1:0] word_q;
    logic [BU_W-1:0]   step_q;
    logic [DIV_W-1:0]  thr_q;
    logic              seen_q;
    logic              lock_q;
    logic              run_q;
    ch_mode_e          mode;

    logic pending, lock_hit, commit;

    always_comb begin
        pending  = req_pending(word_q);
        lock_hit = wr && pending && !lock_q;
        commit   = !lock_q && pending && !wr && (wrap || !run_q);
        if (lock_q)     mode = CH_LOCKED;
        else if (run_q) mode = CH_RUN;
        else            mode = CH_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            step_q <= '0;
            thr_q  <= '0;
            seen_q <= 1'b0;
            lock_q <= 1'b0;
            run_q  <= 1'b0;
        end else begin
            if (wr)
                word_q <= wdata;
            else if (commit)
                word_q[UPD_BIT] <= 1'b0;
            if (lock_hit)
                lock_q <= 1'b1;
            if (commit) begin
                step_q <= word_q[BU_LSB +: BU_W];
                thr_q  <= thr_of(word_q);
                seen_q <= 1'b1;
            end
            if (mode != CH_LOCKED && !lock_hit)
                run_q <= word_q[EN_BIT] && seen_q;
        end
    end

    assign word_o = word_q;
    assign step_o = step_q;
    assign thr_o  = thr_q;
    assign run_o  = run_q;

    // R7: a lock lasts until reset
    assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        lock_q |=> lock_q);

    // R7: a locked channel keeps its active values and run state
    assert_lock_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        lock_q |=> ($stable(step_q) && $stable(thr_q) && $stable(run_q)));

    // R5: running requires an earlier commit
    assert_run_needs_commit_R5: assert property (@(posedge clk) disable iff (rst)
        run_q |-> seen_q);

    // R4: the request flag drops by hardware only at a wrap or while idle
    assert_req_clear_point_R4: assert property (@(posedge clk) disable iff (rst)
        ($fell(word_q[UPD_BIT]) && !$past(wr)) |->
            (!$past(lock_q) && ($past(wrap) || !$past(run_q))));
endmodule

// File: rtl/pwm_stage_wave.sv
module pwm_stage_wave
    import pwm_stage_pkg::*;
#(
    parameter int BU_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [BU_W-1:0]  step,
    input  logic [DIV_W-1:0] thr,
    output logic             wrap_o,
    output logic             out_o
);
    localparam logic [BU_W:0] MOD_V = {1'b0, {BU_W{1'b1}}};

    logic [BU_W-1:0] acc_q;
    logic [BU_W:0]   sum;
    logic [BU_W:0]   sum_wrapped;
    logic            wrap;
    logic            out_q;

    always_comb begin
        sum         = {1'b0, acc_q} + {1'b0, step};
        wrap        = run && (sum >= MOD_V);
        sum_wrapped = sum - MOD_V;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            out_q <= 1'b0;
        end else begin
            if (!run)
                acc_q <= '0;
            else if (wrap)
                acc_q <= sum_wrapped[BU_W-1:0];
            else
                acc_q <= sum[BU_W-1:0];
            out_q <= run && (acc_q[BU_W-1 -: DIV_W] >= thr);
        end
    end

    assign wrap_o = wrap;
    assign out_o  = out_q;

    // R2: the accumulator never reaches the modulus
    assert_acc_in_range_R2: assert property (@(posedge clk) disable iff (rst)
        {1'b0, acc_q} < MOD_V);

    // R6: a stopped channel clears its accumulator and output
    assert_stop_clears_R6: assert property (@(posedge clk) disable iff (rst)
        !run |=> (acc_q == '0 && !out_q));

    // R3: a high output always follows a running cycle
    assert_high_needs_run_R3: assert property (@(posedge clk) disable iff (rst)
        out_q |-> $past(run));
endmodule

// File: rtl/pwm_stage.sv
module pwm_stage
    import pwm_stage_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int BU_W   = 16,
    localparam int AW    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [AW-1:0]     addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic [NUM_CH-1:0] pwm_out
);
    logic [WORD_W-1:0] words [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic            sel_wr;
        logic            wrap;
        logic            run;
        logic [BU_W-1:0] step;
        logic [DIV_W-1:0] thr;

        assign sel_wr = wr_en && (addr == AW'(g));

        pwm_stage_ctl #(.BU_W(BU_W)) u_ctl (
            .clk    (clk),
            .rst    (rst),
            .wr     (sel_wr),
            .wdata  (wdata),
            .wrap   (wrap),
            .word_o (words[g]),
            .step_o (step),
            .thr_o  (thr),
            .run_o  (run)
        );

        pwm_stage_wave #(.BU_W(BU_W)) u_wave (
            .clk    (clk),
            .rst    (rst),
            .run    (run),
            .step   (step),
            .thr    (thr),
            .wrap_o (wrap),
            .out_o  (pwm_out[g])
        );
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CH; i++)
            if (addr == AW'(i)) rdata = words[i];
    end
endmodule

// File: tb/sim_pwm_stage.sv
module sim_pwm_stage;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  pwm_out;

    int total = 0;
    int bad = 0;
    bit ended = 0;

    typedef struct { int ch; int exp; string tag; } win_t;
    win_t sb_q[$];
    int pushed = 0;
    int done = 0;

    always #4 clk = ~clk;

    pwm_stage #(.NUM_CH(4), .BU_W(16)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
    );

    task automatic chk(string tag, longint act, longint exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(int step, int thr, bit req, bit en);
        logic [31:0] w = '0;
        w[31]     = en;
        w[30]     = req;
        w[8 +: 16] = step[15:0];
        w[7:0]    = thr[7:0];
        return w;
    endfunction

    task automatic wr(int ch, logic [31:0] d);
        @(negedge clk);
        addr = ch[1:0]; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(int ch, output logic [31:0] v);
        addr = ch[1:0];
        #1 v = rdata;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // driver side of the scoreboard: queue an expected high count for a 15-clock window
    task automatic expect_win(int ch, int exp, string tag);
        win_t e;
        e.ch = ch; e.exp = exp; e.tag = tag;
        sb_q.push_back(e);
        pushed++;
        wait (done == pushed);
    endtask

    // monitor: counts high cycles and compares against the queued item
    initial begin
        forever begin
            win_t e;
            int cnt;
            wait (sb_q.size() > 0);
            e = sb_q.pop_front();
            cnt = 0;
            repeat (15) begin
                @(negedge clk);
                cnt += int'(pwm_out[e.ch]);
            end
            chk(e.tag, cnt, e.exp);
            done++;
        end
    end

    initial begin
        #(8 * 150000);
        if (!ended) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        idle(5);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        rd(0, v); chk("R1 ch0 word after reset", v, 0);
        rd(3, v); chk("R1 ch3 word after reset", v, 0);
        chk("R1 outputs after reset", pwm_out, 0);

        // R5 enable with no commit keeps the output idle
        wr(0, mk(4369, 128, 0, 1));
        idle(20);
        expect_win(0, 0, "R5 enable before any commit");

        // R4 idle commit on the next clock
        wr(0, mk(4369, 128, 1, 1));
        rd(0, v); chk("R4 request flag set after write", v[30], 1);
        @(negedge clk);
        rd(0, v); chk("R4 idle commit clears flag", v[30], 0);
        idle(20);
        expect_win(0, 7, "R3 threshold 128 step 4369");

        // R4 running commit waits for the wrap
        wr(0, mk(4369, 0, 1, 1));
        rd(0, v); chk("R4 flag pending while running", v[30], 1);
        idle(18);
        rd(0, v); chk("R4 flag cleared after wrap", v[30], 0);
        idle(3);
        expect_win(0, 15, "R3 threshold 0 always high");

        wr(0, mk(4369, 255, 1, 1));
        idle(20);
        expect_win(0, 0, "R3 threshold 255 never high");

        wr(0, mk(4369, 200, 1, 1));
        idle(20);
        expect_win(0, 3, "R3 threshold 200");

        // R2 frequency set by the step
        wr(0, mk(13107, 128, 1, 1));
        idle(20);
        expect_win(0, 6, "R2 step 13107 period 5");

        // R6 disable then resume without a new request
        wr(0, mk(13107, 128, 0, 0));
        idle(2);
        chk("R6 output low after disable", pwm_out[0], 0);
        expect_win(0, 0, "R6 stays low while disabled");
        wr(0, mk(13107, 128, 0, 1));
        idle(4);
        expect_win(0, 6, "R6 resume keeps active values");

        // R8 second channel independent
        wr(1, mk(4369, 200, 1, 1));
        idle(20);
        expect_win(1, 3, "R8 ch1 own waveform");
        expect_win(0, 6, "R8 ch0 undisturbed");
        rd(1, v); chk("R8 ch1 read", v, mk(4369, 200, 0, 1));

        // R7 lock: second write while a request is pending
        wr(0, mk(4369, 0, 1, 1));
        wr(0, mk(4369, 255, 1, 0));
        idle(20);
        rd(0, v); chk("R7 locked word read back", v, mk(4369, 255, 1, 0));
        expect_win(0, 6, "R7 locked waveform unchanged");
        wr(0, mk(4369, 0, 0, 0));
        idle(20);
        rd(0, v); chk("R7 later write stored", v, mk(4369, 0, 0, 0));
        expect_win(0, 6, "R7 later write no effect");
        expect_win(1, 3, "R8 ch1 unaffected by ch0 lock");

        // reset releases the lock
        @(negedge clk) rst = 1'b1;
        idle(2);
        @(negedge clk) rst = 1'b0;
        rd(0, v); chk("R1 word cleared by reset", v, 0);
        chk("R1 outputs low after reset", pwm_out, 0);
        wr(0, mk(4369, 128, 1, 1));
        idle(20);
        expect_win(0, 7, "R7 reset releases lock");

        ended = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule